// File: doc/BRIEF.md
# Packed GF(2) Byte Affine Unit

This block applies an affine map over GF(2) to every byte of a packed vector. For each byte, the eight result bits are formed by multiplying an 8x8 bit matrix with the byte, where the product is the parity of an AND. An 8-bit constant is then XORed into the result. The matrix operand is cut into 64-bit lanes. Each lane holds its own matrix, and that matrix acts only on the eight data bytes in the same lane. The constant is common to every byte of every lane.

The active vector width `ACT_W` is 128, 256 or 512 bits. The result port is `MAX_W` bits wide, and bits above the active width are held at zero. The unit has three register stages and never stalls. A new operand set may be presented on every cycle. Typical uses include bit reversal inside each byte, bit permutation, shifts, and the affine steps of finite-field ciphers.

Top module: `gf2_affine_vec`

## Requirements
- R1: Result bit i of each byte equals the parity of (data byte AND matrix row byte for bit i), XORed with bit i of `cst_in`.
- R2: Within a lane, matrix byte k (bits 8k+7:8k of that lane) builds result bit 7-k. Byte 0 builds bit 7 and byte 7 builds bit 0.
- R3: Lane n of `mtx_in` (bits 64n+63:64n) is the matrix for data bytes 8n to 8n+7 only. Each lane works independently of the others.
- R4: The same `cst_in` is applied to every byte position in every lane.
- R5: A lane matrix of 64'h0102040810204080 gives result byte = data byte XOR `cst_in`.
- R6: A lane matrix of 64'h8040201008040201 with `cst_in` = 0 gives each data byte with its bit order reversed.
- R7: An all-zero lane matrix gives `cst_in` in every result byte of that lane.
- R8: Operands sampled at rising edge E produce a result on `res_out` after edge E+2. One operand set is accepted on every cycle, with no stall.
- R9: `out_vld` equals `in_vld` delayed by three edges. The synchronous active-high `rst` clears `out_vld` and `res_out` to zero.
- R10: `res_out` bits from `ACT_W` up to `MAX_W-1` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand strobe |
| data_in | input | ACT_W | Packed data bytes |
| mtx_in | input | ACT_W | One 8x8 matrix per 64-bit lane |
| cst_in | input | 8 | Constant XORed into every result byte |
| out_vld | output | 1 | Result strobe |
| res_out | output | MAX_W | Packed result bytes, zero above ACT_W |

## Verification
The hardest case to reach from the ports is a stream where consecutive operand sets carry different matrices, data and constants in every lane. Only such a stream shows that no stage mixes values from neighbouring cycles or neighbouring lanes. The bench drives this case with back-to-back random operand sets on consecutive edges, and matches each output cycle against the operand set sent three edges earlier. It also drives one vector whose four lanes hold the identity, reversal, zero and random matrices at the same time. This separates the lanes and exposes any row-order or lane-offset error.

// File: rtl/gf2_affine_vec.sv
module gf2_affine_vec #(
  parameter int MAX_W = 512,
  parameter int ACT_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [ACT_W-1:0] data_in,
  input  logic [ACT_W-1:0] mtx_in,
  input  logic [7:0]       cst_in,
  output logic             out_vld,
  output logic [MAX_W-1:0] res_out
);
  localparam int NBYTE = ACT_W / 8;

  logic [2:0]       vld_sr;
  logic [ACT_W-1:0] s1_d, s1_m;
  logic [7:0]       s1_c, s2_c;
  logic [NBYTE-1:0][7:0][7:0] and_n, s2_and;
  logic [ACT_W-1:0] res_n, res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_sr <= '0;
      s1_d   <= '0;
      s1_m   <= '0;
      s1_c   <= '0;
      s2_c   <= '0;
      s2_and <= '0;
      res_q  <= '0;
    end else begin
      vld_sr <= {vld_sr[1:0], in_vld};
      s1_d   <= data_in;
      s1_m   <= mtx_in;
      s1_c   <= cst_in;
      s2_and <= and_n;
      s2_c   <= s1_c;
      res_q  <= res_n;
    end
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    localparam int LBASE = (b / 8) * 64;
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign and_n[b][i]    = s1_d[8*b +: 8] & s1_m[LBASE + 8*(7-i) +: 8];
      assign res_n[8*b + i] = (^s2_and[b][i]) ^ s2_c[i];
    end
  end

  if (MAX_W > ACT_W) begin : g_pad
    assign res_out = {{(MAX_W-ACT_W){1'b0}}, res_q};
  end else begin : g_full
    assign res_out = res_q;
  end

  assign out_vld = vld_sr[2];
endmodule

// File: rtl/gf2_affine_vec_chk.sv
module gf2_affine_vec_chk #(
  parameter int MAX_W = 512,
  parameter int ACT_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [ACT_W-1:0] data_in,
  input logic [ACT_W-1:0] mtx_in,
  input logic [7:0]       cst_in,
  input logic             out_vld,
  input logic [MAX_W-1:0] res_out
);
  logic [1:0] age;
  logic       warm;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  assert_rst_clear_R9: assert property (@(posedge clk) rst |=> (!out_vld && res_out == '0));

  assert_vld_delay_R9: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_vld == $past(in_vld, 3)));

  assert_zero_mtx_R7: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_vld, 3) && $past(mtx_in[63:0], 3) == 64'h0)
      |-> (res_out[63:0] == {8{$past(cst_in, 3)}}));

  assert_identity_R5: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_vld, 3) && $past(mtx_in[63:0], 3) == 64'h0102040810204080)
      |-> (res_out[7:0] == ($past(data_in[7:0], 3) ^ $past(cst_in, 3))));

  if (MAX_W > ACT_W) begin : g_hi
    assert_hi_zero_R10: assert property (@(posedge clk) disable iff (rst)
      res_out[MAX_W-1:ACT_W] == '0);
  end
endmodule

bind gf2_affine_vec gf2_affine_vec_chk #(.MAX_W(MAX_W), .ACT_W(ACT_W)) u_chk (.*);

// File: tb/sim_gf2_affine_vec.sv
`timescale 1ns/1ps
module sim_gf2_affine_vec;
  localparam int MW = 512;
  localparam int AW = 256;
  localparam int NB = AW / 8;
  localparam logic [63:0] M_ID  = 64'h0102040810204080;
  localparam logic [63:0] M_REV = 64'h8040201008040201;

  logic clk = 0, rst = 1, in_vld = 0;
  logic [AW-1:0] data_in = '0, mtx_in = '0;
  logic [7:0] cst_in = '0;
  logic out_vld;
  logic [MW-1:0] res_out;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  gf2_affine_vec #(.MAX_W(MW), .ACT_W(AW)) u0 (.*);

  function automatic logic [MW-1:0] ref_v(logic [AW-1:0] d, logic [AW-1:0] m, logic [7:0] c);
    logic [MW-1:0] r = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 8; i++)
        r[8*b+i] = (^(d[8*b +: 8] & m[(b/8)*64 + 8*(7-i) +: 8])) ^ c[i];
    return r;
  endfunction

  function automatic logic [AW-1:0] rnd();
    logic [AW-1:0] v;
    for (int k = 0; k < AW/32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(string tag, logic [MW-1:0] act, logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(logic [AW-1:0] d, logic [AW-1:0] m, logic [7:0] c,
                         string tag, logic [MW-1:0] exp);
    @(negedge clk);
    data_in = d; mtx_in = m; cst_in = c; in_vld = 1;
    @(negedge clk);
    in_vld = 0;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " vld"}, {{(MW-1){1'b0}}, out_vld}, 1);
    chk(tag, res_out, exp);
    @(negedge clk);
    chk({tag, " vld drop R9"}, {{(MW-1){1'b0}}, out_vld}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 reset vld", {{(MW-1){1'b0}}, out_vld}, 0);
    chk("R9 reset res", res_out, '0);
    rst = 0;
  endtask

  task automatic t_identity();
    logic [AW-1:0] d = rnd();
    logic [AW-1:0] e;
    for (int b = 0; b < NB; b++) e[8*b +: 8] = d[8*b +: 8] ^ 8'h5A;
    run_one(d, {(AW/64){M_ID}}, 8'h5A, "R5 R4 identity", {{(MW-AW){1'b0}}, e});
  endtask

  task automatic t_reverse();
    logic [AW-1:0] d = rnd();
    logic [AW-1:0] e;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 8; i++) e[8*b+i] = d[8*b+7-i];
    run_one(d, {(AW/64){M_REV}}, 8'h00, "R6 reverse", {{(MW-AW){1'b0}}, e});
  endtask

  task automatic t_zero();
    logic [AW-1:0] e;
    for (int b = 0; b < NB; b++) e[8*b +: 8] = 8'hC3;
    run_one(rnd(), '0, 8'hC3, "R7 zero matrix", {{(MW-AW){1'b0}}, e});
  endtask

  task automatic t_row_order();
    logic [AW-1:0] d = '0, m = '0, e = '0;
    d[7:0] = 8'h01; m[7:0] = 8'hFF; e[7:0] = 8'h80;
    run_one(d, m, 8'h00, "R2 row0 to bit7", {{(MW-AW){1'b0}}, e});
    d = '0; m = '0; e = '0;
    d[7:0] = 8'h80; m[63:56] = 8'h80; e[7:0] = 8'h01;
    run_one(d, m, 8'h00, "R2 row7 to bit0", {{(MW-AW){1'b0}}, e});
  endtask

  task automatic t_lanes();
    logic [AW-1:0] d = rnd();
    logic [AW-1:0] m = {rnd()} ;
    m[63:0] = M_ID; m[127:64] = M_REV; m[191:128] = '0;
    run_one(d, m, 8'h00, "R3 mixed lanes", ref_v(d, m, 8'h00));
    run_one(d, m, 8'h96, "R3 R4 mixed lanes cst", ref_v(d, m, 8'h96));
  endtask

  task automatic t_random();
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] d = rnd(), m = rnd();
      logic [7:0] c = 8'($urandom);
      run_one(d, m, c, "R1 random", ref_v(d, m, c));
    end
  endtask

  task automatic t_stream();
    localparam int N = 8;
    logic [AW-1:0] ds [N], ms [N];
    logic [7:0] cs [N];
    for (int k = 0; k < N; k++) begin
      ds[k] = rnd(); ms[k] = rnd(); cs[k] = 8'($urandom);
    end
    @(negedge clk);
    data_in = ds[0]; mtx_in = ms[0]; cst_in = cs[0]; in_vld = 1;
    for (int t = 0; t < N + 3; t++) begin
      @(negedge clk);
      if (t >= 2 && t - 2 < N) begin
        chk("R8 stream vld", {{(MW-1){1'b0}}, out_vld}, 1);
        chk("R8 R1 stream data", res_out, ref_v(ds[t-2], ms[t-2], cs[t-2]));
      end else begin
        chk("R9 stream idle", {{(MW-1){1'b0}}, out_vld}, 0);
      end
      if (t + 1 < N) begin
        data_in = ds[t+1]; mtx_in = ms[t+1]; cst_in = cs[t+1]; in_vld = 1;
      end else in_vld = 0;
    end
    chk("R10 upper zero", {{AW{1'b0}}, res_out[MW-1:AW]}, '0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_identity();
    t_reverse();
    t_zero();
    t_row_order();
    t_lanes();
    t_random();
    t_stream();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule